// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

A small processor built around one accumulator register. It runs programs kept in a single read-write memory that holds both instructions and data. No tag marks a word as code or data: the only difference is how a word is reached. In a fetch the core reads the word addressed by its program counter into its instruction register and advances the counter. In the following execute step it decodes the four-bit opcode and acts on the memory word named by the address field. The memory is synchronous and single-ported. Read data appears one cycle after the address, so each memory read is followed by a wait phase.

The instruction word is `4 + ADDR_W` bits wide. The opcode sits in the top four bits and the operand address in the low `ADDR_W` bits, so the default is a 16-bit word with a 12-bit address. Data words have the same width and are held in sign-magnitude form: the top bit is the sign (1 = negative) and the rest is the magnitude. Three operations exist: load accumulator, store accumulator and add to accumulator. Any other opcode stops the core and raises a halt flag until reset. Debug outputs show the program counter, the instruction register and the accumulator.

Top module: `acc_core`

## Requirements
- R1: While reset (`rst_n` low) is active, `dbg_pc`, `dbg_ir` and `dbg_ac` read zero, `halted` and `ovf` are low, and `mem_we` is low.
- R2: A fetch reads the word at address `dbg_pc` into `dbg_ir` and raises `dbg_pc` by one, wrapping modulo 2^ADDR_W.
- R3: Instructions follow one phase sequence. The phases are fetch (address = PC), fetch wait, execute (address = the IR address field), and operand wait for load and add only. Load and add therefore take 4 cycles and store takes 3. The first store after reset in a load, add, store program raises `mem_we` in the 10th cycle after the first clock edge following release of reset.
- R4: Opcode 0001 (top four bits of the instruction) copies the addressed memory word into the accumulator unchanged, including a negative zero.
- R5: Opcode 0010 drives `mem_addr` with the address field, `mem_wdata` with the accumulator, and `mem_we` high for exactly one cycle. The accumulator is left unchanged.
- R6: Opcode 0101 with operands of equal sign sets the accumulator to the sum of the magnitudes with that sign.
- R7: Opcode 0101 with operands of opposite sign sets the accumulator to the larger magnitude minus the smaller, with the sign of the larger. Any zero result of an add, including one from a wrapped overflow, has a positive sign.
- R8: When an equal-sign add carries out of the magnitude field, the accumulator keeps the low magnitude bits and `ovf` rises. `ovf` then stays high until reset.
- R9: Any opcode other than 0001, 0010 or 0101 raises `halted` in the execute phase. From then until reset there is no memory write, and the PC, IR and accumulator keep their values. The PC already points past the bad instruction.
- R10: A word written by a store can later be fetched and executed as an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 4+ADDR_W | Memory write data (the accumulator) |
| mem_rdata | input | 4+ADDR_W | Memory read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | Core stopped on an illegal opcode |
| ovf | output | 1 | Sticky add-overflow flag |
| dbg_pc | output | ADDR_W | Program counter |
| dbg_ir | output | 4+ADDR_W | Instruction register |
| dbg_ac | output | 4+ADDR_W | Accumulator |

## Verification
The bench builds the core with `ADDR_W = 8`, which gives a 256-word memory and 12-bit words with an 11-bit magnitude. An overflow is then reached with operands near 2047. A program of back-to-back loads runs the program counter through its wrap after 256 instructions, about a thousand cycles. Changing word 0 while that program runs proves the wrapped fetch really returns to address 0. The same small memory also lets a store rewrite a later instruction, which shows that code and data share one space.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'b0001;
  localparam logic [OPC_W-1:0] OP_STORE = 4'b0010;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'b0101;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_FWAIT,
    PH_EXEC,
    PH_OWAIT,
    PH_HALT
  } phase_t;

  typedef struct packed {
    logic ld;
    logic st;
    logic add;
    logic bad;
  } op_kind_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output op_kind_t         kind
);
  always_comb begin
    kind = '0;
    unique case (opc)
      OP_LOAD:  kind.ld  = 1'b1;
      OP_STORE: kind.st  = 1'b1;
      OP_ADD:   kind.add = 1'b1;
      default:  kind.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_kind_t kind,
  output logic     ir_load,
  output logic     use_ir_addr,
  output logic     wr_strobe,
  output logic     ac_load,
  output logic     halt
);
  phase_t ph, ph_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_FETCH;
    else        ph <= ph_nx;
  end

  always_comb begin
    ph_nx = ph;
    case (ph)
      PH_FETCH: ph_nx = PH_FWAIT;
      PH_FWAIT: ph_nx = PH_EXEC;
      PH_EXEC: begin
        if (kind.bad)                 ph_nx = PH_HALT;
        else if (kind.ld || kind.add) ph_nx = PH_OWAIT;
        else                          ph_nx = PH_FETCH;
      end
      PH_OWAIT: ph_nx = PH_FETCH;
      PH_HALT:  ph_nx = PH_HALT;
      default:  ph_nx = PH_HALT;
    endcase
  end

  assign ir_load     = (ph == PH_FWAIT);
  assign use_ir_addr = (ph == PH_EXEC);
  assign wr_strobe   = (ph == PH_EXEC) && kind.st;
  assign ac_load     = (ph == PH_OWAIT);
  assign halt        = (ph == PH_HALT);

  // R9: the halt phase is absorbing
  a_r9_halt_absorbing: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  // R3: an execute phase always follows the instruction capture
  a_r3_exec_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> use_ir_addr);
endmodule

// File: rtl/acc_smadd.sv
module acc_smadd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         ovf
);
  localparam int M = W - 1;

  // returns {overflow, sign, magnitude}
  function automatic logic [W:0] sm_add(input logic [W-1:0] x, input logic [W-1:0] y);
    logic         sx, sy, s;
    logic [M-1:0] mx, my, m;
    logic [M:0]   wide;
    logic         c;
    sx = x[W-1];
    sy = y[W-1];
    mx = x[M-1:0];
    my = y[M-1:0];
    c  = 1'b0;
    if (sx == sy) begin
      wide = {1'b0, mx} + {1'b0, my};
      c    = wide[M];
      m    = wide[M-1:0];
      s    = sx;
    end else if (mx >= my) begin
      m = mx - my;
      s = sx;
    end else begin
      m = my - mx;
      s = sy;
    end
    if (m == '0) s = 1'b0;
    return {c, s, m};
  endfunction

  logic [W:0] res;
  assign res = sm_add(a, b);
  assign ovf = res[W];
  assign sum = res[W-1:0];
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic              halted,
  output logic              ovf,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_ir,
  output logic [DATA_W-1:0] dbg_ac
);
  localparam logic [DATA_W-1:0] NEG_ZERO = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] PC_ONE   = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir, acc;
  logic              ovf_q;
  op_kind_t          kind;
  logic              ir_load, use_ir_addr, wr_strobe, ac_load, halt;
  logic [DATA_W-1:0] add_sum;
  logic              add_ovf;

  acc_decode u_dec (
    .opc  (ir[DATA_W-1 -: OPC_W]),
    .kind (kind)
  );

  acc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .kind        (kind),
    .ir_load     (ir_load),
    .use_ir_addr (use_ir_addr),
    .wr_strobe   (wr_strobe),
    .ac_load     (ac_load),
    .halt        (halt)
  );

  acc_smadd #(.W(DATA_W)) u_add (
    .a   (acc),
    .b   (mem_rdata),
    .sum (add_sum),
    .ovf (add_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      ir    <= '0;
      acc   <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (ir_load) begin
        ir <= mem_rdata;
        pc <= pc + PC_ONE;
      end
      if (ac_load) begin
        if (kind.ld) begin
          acc <= mem_rdata;
        end else begin
          acc <= add_sum;
          if (add_ovf) ovf_q <= 1'b1;
        end
      end
    end
  end

  assign mem_addr  = use_ir_addr ? ir[ADDR_W-1:0] : pc;
  assign mem_wdata = acc;
  assign mem_we    = wr_strobe;
  assign halted    = halt;
  assign ovf       = ovf_q;
  assign dbg_pc    = pc;
  assign dbg_ir    = ir;
  assign dbg_ac    = acc;

  // R2: each capture advances the PC by one, modulo the address space
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (pc == ADDR_W'($past(pc) + PC_ONE)));

  // R3: capture, accumulator update and write never coincide
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ir_load, ac_load, mem_we}));

  // R4: a load copies the read word verbatim
  a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_load && kind.ld) |=> (acc == $past(mem_rdata)));

  // R5: a store leaves the accumulator alone
  a_r5_store_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> $stable(acc));

  // R7: an add never leaves a negative zero
  a_r7_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_load && kind.add) |=> (acc != NEG_ZERO));

  // R8: overflow flag is sticky
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R9: a halted core is frozen and silent
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc) && $stable(ir) && $stable(acc) && !mem_we));
endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;
  localparam int AW     = 8;
  localparam int DW     = AW + 4;
  localparam int MAGW   = DW - 1;
  localparam int MAXMAG = (1 << MAGW) - 1;
  localparam int DEPTH  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_we, halted, ovf;
  logic [AW-1:0] dbg_pc;
  logic [DW-1:0] dbg_ir, dbg_ac;

  acc_core #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .halted(halted), .ovf(ovf),
    .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_ac(dbg_ac)
  );

  // memory model with a bench load port
  logic [DW-1:0] mem [DEPTH];
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  always @(posedge clk) begin
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int total = 0;
  int bad = 0;
  int    qa[$];
  int    qd[$];
  string qt[$];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int enc(input int v);
    return (v < 0) ? ((1 << MAGW) | (-v)) : v;
  endfunction

  function automatic int ins(input int op, input int a);
    return (op << AW) | a;
  endfunction

  // signed-integer formulation of the sign-magnitude add
  task automatic model_add(input int aw, input int bw, output int rw, output bit ov);
    int va, vb, s, m;
    va = ((aw >> MAGW) & 1) ? -(aw & MAXMAG) : (aw & MAXMAG);
    vb = ((bw >> MAGW) & 1) ? -(bw & MAXMAG) : (bw & MAXMAG);
    s  = va + vb;
    m  = (s < 0) ? -s : s;
    ov = (m > MAXMAG);
    m  = m & MAXMAG;
    rw = (m == 0) ? 0 : ((s < 0) ? ((1 << MAGW) | m) : m);
  endtask

  task automatic expect_store(input int a, input int d, input string t);
    qa.push_back(a);
    qd.push_back(d);
    qt.push_back(t);
  endtask

  // scoreboard monitor
  int    m_a, m_d;
  string m_t;
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (qa.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R9 unexpected write act=%0h:%0h exp=none", mem_addr, mem_wdata);
      end else begin
        m_a = qa.pop_front();
        m_d = qd.pop_front();
        m_t = qt.pop_front();
        chk(m_t, int'(mem_addr), m_a);
        chk(m_t, int'(mem_wdata), m_d);
      end
    end
  end

  task automatic poke(input int a, input int d);
    ld_addr = AW'(a);
    ld_data = DW'(d);
    ld_en   = 1'b1;
    @(negedge clk);
    ld_en   = 1'b0;
  endtask

  task automatic fill(input int v);
    for (int i = 0; i < DEPTH; i++) poke(i, v);
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_reset_state();
    chk("R1 pc", int'(dbg_pc), 0);
    chk("R1 ir", int'(dbg_ir), 0);
    chk("R1 ac", int'(dbg_ac), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 we", int'(mem_we), 0);
  endtask

  task automatic wait_halt(input int limit, input string tag);
    int n;
    n = 0;
    while (!halted && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(tag, int'(halted), 1);
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ac, n;
    bit ov;

    // reset state
    enter_reset();
    check_reset_state();

    // ---- Test A: load / add / store, sign cases, timing
    fill(0);
    poke(0,  ins(1, 'h40));
    poke(1,  ins(5, 'h41));
    poke(2,  ins(2, 'h60));
    poke(3,  ins(5, 'h42));
    poke(4,  ins(2, 'h61));
    poke(5,  ins(5, 'h43));
    poke(6,  ins(2, 'h62));
    poke(7,  ins(1, 'h44));
    poke(8,  ins(2, 'h63));
    poke(9,  ins(5, 'h44));
    poke(10, ins(2, 'h64));
    poke(11, ins(5, 'h45));
    poke(12, ins(2, 'h65));
    poke('h40, enc(300));
    poke('h41, enc(500));
    poke('h42, enc(-1000));
    poke('h43, enc(200));
    poke('h44, 1 << MAGW);
    poke('h45, enc(-7));
    ac = enc(300);
    model_add(ac, enc(500), ac, ov);   expect_store('h60, ac, "R6 same-sign add");
    model_add(ac, enc(-1000), ac, ov); expect_store('h61, ac, "R7 opposite-sign add");
    model_add(ac, enc(200), ac, ov);   expect_store('h62, ac, "R7 cancel to zero");
    ac = 1 << MAGW;                    expect_store('h63, ac, "R4 load negative zero");
    model_add(ac, 1 << MAGW, ac, ov);  expect_store('h64, ac, "R7 neg zero sum");
    model_add(ac, enc(-7), ac, ov);    expect_store('h65, ac, "R7 zero plus negative");
    release_reset();
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 2) begin
        chk("R2 ir after fetch", int'(dbg_ir), ins(1, 'h40));
        chk("R2 pc after fetch", int'(dbg_pc), 1);
      end
      if (n == 4) chk("R4 ac after load", int'(dbg_ac), enc(300));
    end while (!mem_we && n < 40);
    chk("R3 first store cycle", n, 10);
    wait_halt(200, "R9 halt A");
    chk("R9 pc after halt", int'(dbg_pc), 14);
    chk("R7 final ac", int'(dbg_ac), enc(-7));
    chk("R8 no false ovf", int'(ovf), 0);
    chk("R5 all stores seen", qa.size(), 0);

    // ---- Test B: overflow
    enter_reset();
    fill(0);
    poke(0, ins(1, 'h40));
    poke(1, ins(5, 'h41));
    poke(2, ins(2, 'h60));
    poke(3, ins(5, 'h42));
    poke(4, ins(2, 'h61));
    poke(5, ins(1, 'h43));
    poke(6, ins(5, 'h44));
    poke(7, ins(2, 'h62));
    poke('h40, enc(2000));
    poke('h41, enc(100));
    poke('h42, enc(-10));
    poke('h43, enc(-MAXMAG));
    poke('h44, enc(-1));
    ac = enc(2000);
    model_add(ac, enc(100), ac, ov);   expect_store('h60, ac, "R8 wrapped magnitude");
    chk("R8 model overflow", int'(ov), 1);
    model_add(ac, enc(-10), ac, ov);   expect_store('h61, ac, "R8 add after overflow");
    ac = enc(-MAXMAG);
    model_add(ac, enc(-1), ac, ov);    expect_store('h62, ac, "R8 R7 wrap to plus zero");
    release_reset();
    wait_halt(200, "R9 halt B");
    chk("R8 ovf sticky", int'(ovf), 1);
    chk("R5 all stores seen B", qa.size(), 0);
    enter_reset();
    chk("R8 ovf cleared by reset", int'(ovf), 0);

    // ---- Test C: illegal opcode freeze
    fill(0);
    poke(0, ins(1, 'h40));
    poke(1, 'h3AB);
    poke(2, ins(2, 'h60));
    poke('h40, enc(5));
    release_reset();
    wait_halt(100, "R9 halt C");
    chk("R9 pc past bad op", int'(dbg_pc), 2);
    chk("R9 ir holds bad op", int'(dbg_ir), 'h3AB);
    chk("R9 ac kept", int'(dbg_ac), enc(5));
    repeat (20) @(negedge clk);
    chk("R9 pc frozen", int'(dbg_pc), 2);
    chk("R9 still halted", int'(halted), 1);
    enter_reset();
    check_reset_state();

    // ---- Test D: self-modifying program (unified memory)
    fill(0);
    poke(0, ins(1, 'h20));
    poke(1, ins(2, 'h03));
    poke(2, ins(1, 'h21));
    poke('h20, ins(2, 'h22));
    poke('h21, enc(77));
    expect_store('h03, ins(2, 'h22), "R10 write code word");
    expect_store('h22, enc(77), "R10 stored word executed");
    release_reset();
    wait_halt(200, "R9 halt D");
    chk("R10 pc", int'(dbg_pc), 5);
    chk("R10 data landed", int'(mem['h22]), enc(77));
    chk("R5 all stores seen D", qa.size(), 0);

    // ---- Test E: PC wrap
    enter_reset();
    fill(ins(1, 'hFF));
    poke('hFE, ins(2, 'h80));
    expect_store('h80, ins(1, 'hFF), "R5 store near top");
    release_reset();
    n = 0;
    while (dbg_pc != 10 && n < 200) begin
      @(negedge clk);
      n++;
    end
    poke(0, 0);
    wait_halt(3000, "R2 halt after wrap");
    chk("R2 pc after wrap", int'(dbg_pc), 1);
    chk("R2 ir from address 0", int'(dbg_ir), 0);
    chk("R5 all stores seen E", qa.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule